// File: doc/BRIEF.md
# Five-Stage Word-Load Pipeline

This block is a small in-order pipeline that executes 32-bit word loads. It has five stages: fetch, decode, execute, memory access and write-back. A program counter steps through an instruction array. Decode splits the fetched word into its register indices and a sign-extended 12-bit offset, and reads the base register. Execute adds the base and the offset to form a byte address. The memory stage reads one word from a data array at that address. Write-back stores the word into the destination register.

The destination register index travels with the instruction through every pipeline register. It arrives at the register-file write port together with the loaded word, and the write happens on the clock edge after both are captured. There is no hazard detection and no forwarding. A program must place three unrelated instructions, such as no-ops, between a load and any instruction that uses its result.

Both arrays are filled through dedicated write ports while reset is asserted. Results are observed through combinational debug read ports into the register file and the data array.

Top module: `lp_load_pipe`

## Requirements
- R1: While `rst` is high, the program counter is 0, every pipeline stage is empty and every register reads 0 on the debug port. Writes through the preload ports take effect during reset.
- R2: An instruction whose bits [6:0] are 0000011 and whose bits [14:12] are 010 is a word load. Bits [11:7] give the destination, bits [19:15] give the base register, and bits [31:20] give the offset. For example, 0x00412083 loads the word at x2+4 into x1.
- R3: The load address is the base register value plus the sign-extended offset, computed modulo 2^32. The data word index is address bits [9:2], so negative offsets work and all other address bits are ignored.
- R4: A load held at instruction index n updates its destination on the (n+5)th rising edge after reset is released, and not earlier. An instruction placed four slots after the load reads the new value.
- R5: Register x0 always reads 0, and a load that targets x0 changes nothing.
- R6: Any instruction that is not a word load leaves every register unchanged. This covers other opcodes and opcode 0000011 with bits [14:12] other than 010.
- R7: After reset the program counter starts at 0 and advances by 4 every cycle. The instruction array is indexed by PC bits [9:2], and instructions take effect in program order, so a later load to the same register wins.
- R8: The debug ports return register and data-array contents combinationally from their index inputs, and the pipeline never changes the data array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_wr_en | input | 1 | Preload write strobe for the instruction array |
| imem_wr_idx | input | 8 | Instruction array word index for preload |
| imem_wr_data | input | 32 | Instruction word to preload |
| dmem_wr_en | input | 1 | Preload write strobe for the data array |
| dmem_wr_idx | input | 8 | Data array word index for preload |
| dmem_wr_data | input | 32 | Data word to preload |
| dbg_reg_idx | input | 5 | Register index for the debug read |
| dbg_reg_data | output | 32 | Register contents at `dbg_reg_idx` |
| dbg_mem_idx | input | 8 | Data array index for the debug read |
| dbg_mem_data | output | 32 | Data array contents at `dbg_mem_idx` |

## Verification
A directed program first builds a pointer in x2 through a load based on x0, and then runs the load 0x00412083 from that pointer. Sampling x2 after the fourth and fifth edges pins the write-back cycle exactly. The same program also covers several corner cases:
- a load into x0, which shows that x0 writes are dropped;
- a byte-width load and a foreign opcode, which separate real word loads from lookalikes;
- a negative offset and an offset with bit 10 set, which expose wrong sign extension or index slicing;
- two back-to-back loads to one register, which reveal out-of-order write-back.

Random rounds then mix word loads with arbitrary bases, offsets and destinations (x0 included) among random non-load words, all spaced by no-ops. A bench model of each round predicts all 32 registers.

// File: rtl/lp_pkg.sv
package lp_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [6:0] OPC_LOAD = 7'b0000011;
  localparam logic [2:0] F3_WORD  = 3'b010;

  typedef logic [XLEN-1:0] word_t;
  typedef logic [RIDX-1:0] ridx_t;

  typedef enum logic [0:0] {
    ALU_PASS = 1'b0,
    ALU_ADD  = 1'b1
  } alu_op_e;

  // fetch -> decode
  typedef struct packed {
    logic  valid;
    word_t inst;
  } fd_t;

  // decode -> execute
  typedef struct packed {
    logic    valid;
    logic    is_lw;
    alu_op_e op;
    word_t   base;
    word_t   imm;
    ridx_t   rd;
  } dx_t;

  // execute -> memory
  typedef struct packed {
    logic  valid;
    logic  is_lw;
    word_t addr;
    ridx_t rd;
  } xm_t;

  // memory -> write-back
  typedef struct packed {
    logic  valid;
    logic  is_lw;
    word_t data;
    ridx_t rd;
  } mw_t;

  function automatic logic [6:0] fld_opcode(word_t w);
    return w[6:0];
  endfunction

  function automatic ridx_t fld_rd(word_t w);
    return w[11:7];
  endfunction

  function automatic logic [2:0] fld_f3(word_t w);
    return w[14:12];
  endfunction

  function automatic ridx_t fld_rs1(word_t w);
    return w[19:15];
  endfunction

  function automatic ridx_t fld_rs2(word_t w);
    return w[24:20];
  endfunction

  // I-type offset, sign-extended to the full word
  function automatic word_t imm_i(word_t w);
    return {{(XLEN-12){w[31]}}, w[31:20]};
  endfunction

  function automatic logic is_word_load(word_t w);
    return (fld_opcode(w) == OPC_LOAD) && (fld_f3(w) == F3_WORD);
  endfunction

  function automatic word_t agu_sum(word_t a, word_t b);
    return a + b;
  endfunction

endpackage

// File: rtl/lp_word_mem.sv
module lp_word_mem #(
  parameter int AW  = 8,
  parameter int DW  = 32,
  parameter int NRP = 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re    [NRP],
  input  logic [AW-1:0] raddr [NRP],
  output logic [DW-1:0] rdata [NRP]
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // combinational read ports, gated by their enables
  for (genvar p = 0; p < NRP; p++) begin : g_rd
    assign rdata[p] = re[p] ? mem[raddr[p]] : '0;
  end

endmodule

// File: rtl/lp_regfile.sv
module lp_regfile #(
  parameter int AW  = 5,
  parameter int DW  = 32,
  parameter int NRP = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr [NRP],
  output logic [DW-1:0] rdata [NRP]
);

  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs [NREG];
  logic          wr_hit;

  // index 0 is hardwired: a write there is dropped
  assign wr_hit = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        regs[i] <= '0;
      end
    end else if (wr_hit) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
  end

endmodule

// File: rtl/lp_alu.sv
module lp_alu
  import lp_pkg::*;
(
  input  alu_op_e op,
  input  word_t   a,
  input  word_t   b,
  output word_t   y
);

  always_comb begin
    case (op)
      ALU_ADD: y = agu_sum(a, b);
      default: y = a;
    endcase
  end

endmodule

// File: rtl/lp_load_pipe.sv
module lp_load_pipe
  import lp_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              imem_wr_en,
  input  logic [MEM_AW-1:0] imem_wr_idx,
  input  logic [31:0]       imem_wr_data,
  input  logic              dmem_wr_en,
  input  logic [MEM_AW-1:0] dmem_wr_idx,
  input  logic [31:0]       dmem_wr_data,
  input  logic [4:0]        dbg_reg_idx,
  output logic [31:0]       dbg_reg_data,
  input  logic [MEM_AW-1:0] dbg_mem_idx,
  output logic [31:0]       dbg_mem_data
);

  localparam word_t PC_INC = word_t'(XLEN / 8);
  localparam int    IDX_LO = 2;
  localparam int    IDX_HI = MEM_AW + IDX_LO - 1;

  // ---------------- pipeline state ----------------
  word_t pc_q;
  fd_t   fd_q;
  dx_t   dx_q;
  xm_t   xm_q;
  mw_t   mw_q;

  // ---------------- fetch ----------------
  logic              im_re    [1];
  logic [MEM_AW-1:0] im_raddr [1];
  word_t             im_rdata [1];
  word_t             fetch_word;

  assign im_re[0]    = 1'b1;
  assign im_raddr[0] = pc_q[IDX_HI:IDX_LO];
  assign fetch_word  = im_rdata[0];

  lp_word_mem #(.AW(MEM_AW), .DW(XLEN), .NRP(1)) u_imem (
    .clk   (clk),
    .we    (imem_wr_en),
    .waddr (imem_wr_idx),
    .wdata (imem_wr_data),
    .re    (im_re),
    .raddr (im_raddr),
    .rdata (im_rdata)
  );

  // ---------------- decode ----------------
  ridx_t rf_raddr [3];
  word_t rf_rdata [3];
  logic  dec_is_lw;
  word_t dec_imm;
  word_t rs1_val;
  word_t rs2_val;
  logic  rf_we;

  assign dec_is_lw   = fd_q.valid && is_word_load(fd_q.inst);
  assign dec_imm     = imm_i(fd_q.inst);
  assign rf_raddr[0] = fld_rs1(fd_q.inst);
  assign rf_raddr[1] = fld_rs2(fd_q.inst);
  assign rf_raddr[2] = dbg_reg_idx;
  assign rs1_val     = rf_rdata[0];
  assign rs2_val     = rf_rdata[1];   // read but not consumed by a load
  assign dbg_reg_data = rf_rdata[2];

  lp_regfile #(.AW(RIDX), .DW(XLEN), .NRP(3)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (mw_q.rd),
    .wdata (mw_q.data),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  // ---------------- execute ----------------
  word_t alu_y;

  lp_alu u_alu (
    .op (dx_q.op),
    .a  (dx_q.base),
    .b  (dx_q.imm),
    .y  (alu_y)
  );

  // ---------------- memory ----------------
  logic              mem_rd_en;
  logic              dm_re    [2];
  logic [MEM_AW-1:0] dm_raddr [2];
  word_t             dm_rdata [2];
  word_t             mem_word;

  assign mem_rd_en   = xm_q.valid && xm_q.is_lw;
  assign dm_re[0]    = mem_rd_en;
  assign dm_raddr[0] = xm_q.addr[IDX_HI:IDX_LO];
  assign dm_re[1]    = 1'b1;
  assign dm_raddr[1] = dbg_mem_idx;
  assign mem_word    = dm_rdata[0];
  assign dbg_mem_data = dm_rdata[1];

  lp_word_mem #(.AW(MEM_AW), .DW(XLEN), .NRP(2)) u_dmem (
    .clk   (clk),
    .we    (dmem_wr_en),
    .waddr (dmem_wr_idx),
    .wdata (dmem_wr_data),
    .re    (dm_re),
    .raddr (dm_raddr),
    .rdata (dm_rdata)
  );

  // ---------------- write-back ----------------
  assign rf_we = mw_q.valid && mw_q.is_lw;

  // ---------------- stage registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      fd_q <= '0;
      dx_q <= '0;
      xm_q <= '0;
      mw_q <= '0;
    end else begin
      pc_q <= pc_q + PC_INC;
      fd_q <= '{valid: 1'b1, inst: fetch_word};
      dx_q <= '{valid: fd_q.valid,
                is_lw: dec_is_lw,
                op:    (dec_is_lw ? ALU_ADD : ALU_PASS),
                base:  rs1_val,
                imm:   dec_imm,
                rd:    fld_rd(fd_q.inst)};
      xm_q <= '{valid: dx_q.valid,
                is_lw: dx_q.is_lw,
                addr:  alu_y,
                rd:    dx_q.rd};
      mw_q <= '{valid: xm_q.valid,
                is_lw: xm_q.is_lw,
                data:  mem_word,
                rd:    xm_q.rd};
    end
  end

  // ---------------- assertions ----------------
  // R3: the captured memory address is the sum of the operands execute saw
  a_r3_addr_is_sum: assert property (@(posedge clk) disable iff (rst)
    (xm_q.valid && xm_q.is_lw) |-> (xm_q.addr == $past(dx_q.base + dx_q.imm)));

  // R4: a register write follows a data-array read one cycle earlier
  a_r4_mem_before_wb: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(mem_rd_en));

  // R4: the written index is the one execute carried two cycles earlier
  a_r4_rd_carried: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (mw_q.rd == $past(dx_q.rd, 2)));

  // R6: only a decoded word load can reach the write port
  a_r6_only_loads_write: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(dec_is_lw, 3));

  // R5: the second decode read port sees zero for index 0
  a_r5_x0_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (fd_q.valid && (rf_raddr[1] == '0)) |-> (rs2_val == '0));

endmodule

// File: tb/lp_load_pipe_tb.sv
`timescale 1ns/1ps
module lp_load_pipe_tb;

  localparam int DEPTH = 256;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_wr_en = 1'b0;
  logic [7:0]  imem_wr_idx = '0;
  logic [31:0] imem_wr_data = '0;
  logic        dmem_wr_en = 1'b0;
  logic [7:0]  dmem_wr_idx = '0;
  logic [31:0] dmem_wr_data = '0;
  logic [4:0]  dbg_reg_idx = '0;
  logic [31:0] dbg_reg_data;
  logic [7:0]  dbg_mem_idx = '0;
  logic [31:0] dbg_mem_data;

  int n_run  = 0;
  int n_fail = 0;

  logic [31:0] prog [DEPTH];
  logic [31:0] dm   [DEPTH];
  logic [31:0] mrf  [32];

  always #2 clk = ~clk;

  lp_load_pipe u_dut (
    .clk          (clk),
    .rst          (rst),
    .imem_wr_en   (imem_wr_en),
    .imem_wr_idx  (imem_wr_idx),
    .imem_wr_data (imem_wr_data),
    .dmem_wr_en   (dmem_wr_en),
    .dmem_wr_idx  (dmem_wr_idx),
    .dmem_wr_data (dmem_wr_data),
    .dbg_reg_idx  (dbg_reg_idx),
    .dbg_reg_data (dbg_reg_data),
    .dbg_mem_idx  (dbg_mem_idx),
    .dbg_mem_data (dbg_mem_data)
  );

  function automatic logic [31:0] enc(logic [11:0] imm, logic [4:0] rs1,
                                      logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] sx12(logic [11:0] v);
    return v[11] ? {20'hFFFFF, v} : {20'h00000, v};
  endfunction

  function automatic logic [7:0] widx(logic [31:0] a);
    return a[9:2];
  endfunction

  // sequential reference: programs keep dependent loads at least four slots apart
  task automatic model_run();
    for (int r = 0; r < 32; r++) mrf[r] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] w;
      logic [31:0] ea;
      w = prog[i];
      if (w[6:0] == 7'h03 && w[14:12] == 3'b010 && w[11:7] != 5'd0) begin
        ea = mrf[w[19:15]] + sx12(w[31:20]);
        mrf[w[11:7]] = dm[widx(ea)];
      end
    end
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic rdreg(input logic [4:0] i, output logic [31:0] v);
    dbg_reg_idx = i;
    #0.2;
    v = dbg_reg_data;
  endtask

  task automatic rdmem(input logic [7:0] i, output logic [31:0] v);
    dbg_mem_idx = i;
    #0.2;
    v = dbg_mem_data;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // hold reset, preload both arrays, check the reset state, then release
  task automatic boot(string tag);
    logic [31:0] v;
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      imem_wr_en = 1'b1; imem_wr_idx = i[7:0]; imem_wr_data = prog[i];
      dmem_wr_en = 1'b1; dmem_wr_idx = i[7:0]; dmem_wr_data = dm[i];
      @(negedge clk);
    end
    imem_wr_en = 1'b0;
    dmem_wr_en = 1'b0;
    repeat (2) @(negedge clk);
    for (int r = 0; r < 32; r++) begin
      rdreg(r[4:0], v);
      chk("R1", $sformatf("%s reg x%0d under reset", tag, r), v, 32'h0);
    end
    for (int k = 0; k < 4; k++) begin
      logic [7:0] ix;
      ix = 8'($urandom);
      rdmem(ix, v);
      chk("R8", $sformatf("%s preload dmem[%0d]", tag, ix), v, dm[ix]);
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_all_regs(string tag);
    logic [31:0] v;
    for (int r = 0; r < 32; r++) begin
      rdreg(r[4:0], v);
      chk("R3", $sformatf("%s x%0d vs model", tag, r), v, mrf[r]);
    end
  endtask

  task automatic check_dmem_kept(string tag);
    logic [31:0] v;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] ix;
      ix = 8'($urandom);
      rdmem(ix, v);
      chk("R8", $sformatf("%s dmem[%0d] untouched", tag, ix), v, dm[ix]);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));

    // ---------------- directed program ----------------
    for (int i = 0; i < DEPTH; i++) begin
      prog[i] = 32'h0;
      dm[i]   = $urandom;
    end
    dm[0]   = 32'h0000_0008;
    dm[1]   = 32'h1111_2222;
    dm[3]   = 32'hCAFE_F00D;
    dm[255] = 32'h8000_0001;

    chk("R2", "encoding of lw x1,4(x2)", enc(12'd4, 5'd2, 3'd2, 5'd1, 7'h03), 32'h0041_2083);

    prog[0]  = enc(12'd0, 5'd0, 3'd2, 5'd2, 7'h03);        // x2 <- dm[0] = 8
    prog[1]  = NOP; prog[2] = NOP; prog[3] = NOP;
    prog[4]  = 32'h0041_2083;                              // x1 <- dm[(8+4)>>2]
    prog[5]  = enc(12'd12, 5'd0, 3'd2, 5'd0, 7'h03);       // x0 target
    prog[6]  = enc(12'd12, 5'd0, 3'd2, 5'd3, 7'h03);       // x3 <- dm[3]
    prog[7]  = enc(12'd12, 5'd0, 3'd0, 5'd5, 7'h03);       // byte width: ignored
    prog[8]  = enc(12'd12, 5'd0, 3'd2, 5'd6, 7'h33);       // other opcode: ignored
    prog[9]  = enc(12'hFFC, 5'd0, 3'd2, 5'd7, 7'h03);      // offset -4
    prog[10] = enc(12'h404, 5'd0, 3'd2, 5'd8, 7'h03);      // bit 10 dropped
    prog[11] = NOP; prog[12] = NOP; prog[13] = NOP;
    prog[14] = enc(12'd1, 5'd3, 3'd2, 5'd9, 7'h03);        // unaligned base
    prog[15] = enc(12'd0, 5'd0, 3'd2, 5'd10, 7'h03);       // x10 <- dm[0]
    prog[16] = enc(12'd4, 5'd0, 3'd2, 5'd10, 7'h03);       // then x10 <- dm[1]
    model_run();

    boot("directed");
    step(4);
    rdreg(5'd2, v);
    chk("R4", "x2 after 4 edges (not yet)", v, 32'h0);
    step(1);
    rdreg(5'd2, v);
    chk("R4", "x2 after 5 edges", v, 32'h0000_0008);
    step(30);
    rdreg(5'd1, v);  chk("R2", "x1 from lw x1,4(x2)", v, 32'hCAFE_F00D);
    rdreg(5'd0, v);  chk("R5", "x0 after load to x0", v, 32'h0);
    rdreg(5'd3, v);  chk("R5", "x3 same address as x0 load", v, 32'hCAFE_F00D);
    rdreg(5'd5, v);  chk("R6", "x5 after byte-width load", v, 32'h0);
    rdreg(5'd6, v);  chk("R6", "x6 after foreign opcode", v, 32'h0);
    rdreg(5'd7, v);  chk("R3", "x7 from offset -4", v, 32'h8000_0001);
    rdreg(5'd8, v);  chk("R3", "x8 from offset 0x404", v, 32'h1111_2222);
    rdreg(5'd10, v); chk("R7", "x10 later load wins", v, 32'h1111_2222);
    check_all_regs("directed");
    check_dmem_kept("directed");

    // ---------------- random rounds ----------------
    for (int rnd = 0; rnd < 8; rnd++) begin
      int n_ins;
      int slot;
      for (int i = 0; i < DEPTH; i++) begin
        prog[i] = 32'h0;
        dm[i]   = $urandom;
      end
      n_ins = 20 + ($urandom % 26);
      slot = 0;
      for (int k = 0; k < n_ins; k++) begin
        logic [6:0] op;
        logic [2:0] f3;
        if (($urandom % 8) == 0) begin
          op = 7'($urandom);
          f3 = 3'($urandom);
          if (op == 7'h03 && f3 == 3'b010) f3 = 3'b011;
        end else begin
          op = 7'h03;
          f3 = 3'b010;
        end
        prog[slot] = enc(12'($urandom), 5'($urandom), f3, 5'($urandom), op);
        prog[slot+1] = NOP;
        prog[slot+2] = NOP;
        prog[slot+3] = NOP;
        slot += 4;
      end
      model_run();
      boot($sformatf("round%0d", rnd));
      step(210);
      check_all_regs($sformatf("round%0d", rnd));
      check_dmem_kept($sformatf("round%0d", rnd));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule